// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the 32-bit write path in front of an embedded flash array. It watches each bus write for a short ordered series of unlock writes: fixed data values written to fixed offsets. When a complete series is seen, it launches one of the array commands: sector erase, configuration-block erase, page-buffer programming, entering page mode, clearing status, or lifting write protection for the current session. The array itself is not modelled. Each accepted erase or program raises a one-cycle operation strobe that carries the kind and target address, and then holds a busy flag for a fixed number of cycles.

Any write that does not fit the series in progress sends the decoder back to idle and sets a sequence-error flag. That flag stays set until a clear-status command. A write that arrives while the block is busy is refused in the same way. Software reads the packed status vector to learn whether the last command was taken. In page mode it also reads the number of word pairs loaded into the page buffer.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, status_o is all zero, op_valid_o is 0 and pairs_o is 0.
- R2: The six-write series AA@5554, 55@AAA8, 80@5554, AA@5554, 55@AAA8, 30@base is a sector erase. It sets erase (status bit 5) and busy (bit 0), and pulses op_valid_o with op_kind_o=0 and op_addr_o=base.
- R3: The same series with C0 as the final value is a configuration-block erase (op_kind_o=1). Any other final value sets sequence error (bit 10) and starts no operation.
- R4: Writing 50 to 5554 sets page mode (bit 6) and resets pairs_o to 0.
- R5: In page mode, a write to 55F0 followed by a write to 55F4 loads one word pair and increments pairs_o. A high word with no pending low word, a low word outside page mode, or a low word once 32 pairs are loaded sets sequence error.
- R6: AA@5554, 55@AAA8, then A0 (normal, op_kind_o=2) or C0 (configuration, op_kind_o=3) @5554, then AA@base programs the page. This sets program (bit 4) and busy, clears page mode and resets pairs_o. Without page mode, the last write sets sequence error instead.
- R7: Writing F5 to 5554 clears program, erase, sequence error and protection error (bits 4, 5, 10, 11). Page mode and unprotect (bit 12) are left unchanged.
- R8: AA@5554, 55@AAA8, level (0 to 2)@553C, key1@AAA8, key2@AAA8, 05@5558 sets unprotect (bit 12) if both keys match the configured ones. Otherwise it sets protection error (bit 11). A level above 2 is a sequence error.
- R9: Busy is high for exactly BUSY_CYCLES cycles after an accepted erase or program.
- R10: A write with a wrong address or data at any step sets sequence error and returns to idle. The next correct series is accepted.
- R11: Any write while busy is refused and sets sequence error.
- R12: Sequence error stays set until a clear-status command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Write offset within the flash window |
| wr_data_i | input | 32 | Write data |
| status_o | output | 16 | Packed status flags (bits 0, 4, 5, 6, 10, 11, 12) |
| op_valid_o | output | 1 | One-cycle strobe for an accepted erase or program |
| op_kind_o | output | 2 | Operation kind: 0 sector erase, 1 config erase, 2 page program, 3 config program |
| op_addr_o | output | ADDR_W | Target address of the last accepted operation |
| pairs_o | output | 6 | Word pairs loaded in the page buffer |

## Verification
The case of interest is the busy window ending on the same clock edge that a refused write raises sequence error. The bench waits BUSY_CYCLES-1 cycles after an accepted erase and then issues a write on the last busy cycle. It then expects busy and sequence error to change together on that edge. A behavioural model compares every output on every clock, so a one-cycle slip in either flag is flagged. The model keeps the pending writes as a list and matches that list against the command patterns.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int DATA_W   = 32;
  localparam int STATUS_W = 16;

  localparam int SB_BUSY = 0;
  localparam int SB_PROG = 4;
  localparam int SB_ERS  = 5;
  localparam int SB_PAGE = 6;
  localparam int SB_SERR = 10;
  localparam int SB_PERR = 11;
  localparam int SB_UNP  = 12;

  localparam int N_TGT = 6;
  localparam int T_CMD = 0;
  localparam int T_KEY = 1;
  localparam int T_LVL = 2;
  localparam int T_FIN = 3;
  localparam int T_LO  = 4;
  localparam int T_HI  = 5;
  localparam logic [15:0] TGT_OFF [N_TGT] =
    '{16'h5554, 16'hAAA8, 16'h553C, 16'h5558, 16'h55F0, 16'h55F4};

  localparam logic [DATA_W-1:0] C_UNL = 32'hAA;
  localparam logic [DATA_W-1:0] C_KEY = 32'h55;
  localparam logic [DATA_W-1:0] C_ERS = 32'h80;
  localparam logic [DATA_W-1:0] C_PGM = 32'hA0;
  localparam logic [DATA_W-1:0] C_CFG = 32'hC0;
  localparam logic [DATA_W-1:0] C_SCT = 32'h30;
  localparam logic [DATA_W-1:0] C_ENT = 32'h50;
  localparam logic [DATA_W-1:0] C_CLR = 32'hF5;
  localparam logic [DATA_W-1:0] C_GO  = 32'h05;
  localparam logic [DATA_W-1:0] C_LVL_MAX = 32'd2;

  typedef enum logic [1:0] {
    OP_SECT_ERASE = 2'd0,
    OP_CFG_ERASE  = 2'd1,
    OP_PAGE_PROG  = 2'd2,
    OP_CFG_PROG   = 2'd3
  } op_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UL1, ST_UL2, ST_ER3, ST_ER4, ST_ER5,
    ST_PW3, ST_UP3, ST_UP4, ST_UP5
  } seq_state_e;
endpackage

// File: rtl/fcs_addr_match.sv
module fcs_addr_match import fcs_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_TGT-1:0]  hit_o
);
  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    assign hit_o[g] = (addr_i == ADDR_W'(TGT_OFF[g]));
  end
endmodule

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
  parameter int CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/fcs_pair_track.sv
module fcs_pair_track #(
  parameter int PAIRS = 32,
  localparam int CNT_W = $clog2(PAIRS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             lo_i,
  input  logic             hi_i,
  output logic             lo_pend_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lo_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lo_q  <= 1'b0;
    end else if (lo_i) begin
      lo_q  <= 1'b1;
    end else if (hi_i) begin
      lo_q  <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lo_pend_o = lo_q;
  assign cnt_o     = cnt_q;
  assign full_o    = (cnt_q == CNT_W'(PAIRS));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder import fcs_pkg::*; #(
  parameter int          ADDR_W      = 16,
  parameter int          BUSY_CYCLES = 20,
  parameter int          PAGE_BYTES  = 256,
  parameter logic [31:0] KEY1        = 32'h1234_5678,
  parameter logic [31:0] KEY2        = 32'h9ABC_DEF0,
  localparam int         PAIRS       = PAGE_BYTES / 8,
  localparam int         PCNT_W      = $clog2(PAIRS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                op_valid_o,
  output logic [1:0]          op_kind_o,
  output logic [ADDR_W-1:0]   op_addr_o,
  output logic [PCNT_W-1:0]   pairs_o
);
  logic [N_TGT-1:0] hit;
  logic busy, lo_pend, full;
  seq_state_e state_q, state_d;
  logic cfg_q, cfg_d, pw_ok_q, pw_ok_d;
  logic pm_q, prog_q, ers_q, serr_q, perr_q, unp_q;
  logic ev_err, ev_clr, ev_ent, ev_ers, ev_pgm, ev_cfg, ev_unp, ev_badpw;
  logic lo_ok, hi_ok, op_go, pg_clr;

  fcs_addr_match #(.ADDR_W(ADDR_W)) u_match (.addr_i(wr_addr_i), .hit_o(hit));

  fcs_busy_timer #(.CYC(BUSY_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(op_go), .busy_o(busy));

  fcs_pair_track #(.PAIRS(PAIRS)) u_pairs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pg_clr), .lo_i(lo_ok), .hi_i(hi_ok),
    .lo_pend_o(lo_pend), .cnt_o(pairs_o), .full_o(full));

  wire d_unl = (wr_data_i == C_UNL);
  wire d_key = (wr_data_i == C_KEY);
  wire d_cfg = (wr_data_i == C_CFG);
  wire d_lvl = (wr_data_i <= C_LVL_MAX);

  always_comb begin
    state_d  = state_q;
    cfg_d    = cfg_q;
    pw_ok_d  = pw_ok_q;
    ev_err   = 1'b0; ev_clr = 1'b0; ev_ent = 1'b0;
    ev_ers   = 1'b0; ev_pgm = 1'b0; ev_cfg = 1'b0;
    ev_unp   = 1'b0; ev_badpw = 1'b0;
    lo_ok    = 1'b0; hi_ok = 1'b0;
    if (wr_en_i) begin
      if (busy) begin
        ev_err = 1'b1;
      end else begin
        // a step that matches nothing falls through as an error
        state_d = ST_IDLE;
        ev_err  = 1'b1;
        unique case (state_q)
          ST_IDLE: begin
            if (hit[T_CMD] && d_unl) begin
              state_d = ST_UL1; ev_err = 1'b0;
            end else if (hit[T_CMD] && wr_data_i == C_ENT) begin
              ev_ent = 1'b1; ev_err = 1'b0;
            end else if (hit[T_CMD] && wr_data_i == C_CLR) begin
              ev_clr = 1'b1; ev_err = 1'b0;
            end else if (hit[T_LO] && pm_q && !lo_pend && !full) begin
              lo_ok = 1'b1; ev_err = 1'b0;
            end else if (hit[T_HI] && pm_q && lo_pend) begin
              hi_ok = 1'b1; ev_err = 1'b0;
            end
          end
          ST_UL1: if (hit[T_KEY] && d_key) begin state_d = ST_UL2; ev_err = 1'b0; end
          ST_UL2: begin
            if (hit[T_CMD] && wr_data_i == C_ERS) begin
              state_d = ST_ER3; ev_err = 1'b0;
            end else if (hit[T_CMD] && (wr_data_i == C_PGM || d_cfg)) begin
              state_d = ST_PW3; cfg_d = d_cfg; ev_err = 1'b0;
            end else if (hit[T_LVL] && d_lvl) begin
              state_d = ST_UP3; ev_err = 1'b0;
            end
          end
          ST_ER3: if (hit[T_CMD] && d_unl) begin state_d = ST_ER4; ev_err = 1'b0; end
          ST_ER4: if (hit[T_KEY] && d_key) begin state_d = ST_ER5; ev_err = 1'b0; end
          ST_ER5: if (wr_data_i == C_SCT || d_cfg) begin
            ev_ers = 1'b1; ev_cfg = d_cfg; ev_err = 1'b0;
          end
          ST_PW3: if (d_unl && pm_q) begin
            ev_pgm = 1'b1; ev_cfg = cfg_q; ev_err = 1'b0;
          end
          ST_UP3: if (hit[T_KEY]) begin
            state_d = ST_UP4; pw_ok_d = (wr_data_i == KEY1); ev_err = 1'b0;
          end
          ST_UP4: if (hit[T_KEY]) begin
            state_d = ST_UP5; pw_ok_d = pw_ok_q && (wr_data_i == KEY2); ev_err = 1'b0;
          end
          ST_UP5: if (hit[T_FIN] && wr_data_i == C_GO) begin
            ev_unp = pw_ok_q; ev_badpw = !pw_ok_q; ev_err = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign op_go  = ev_ers | ev_pgm;
  assign pg_clr = ev_ent | ev_pgm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= 1'b0;
      pw_ok_q <= 1'b0;
      pm_q    <= 1'b0;
      prog_q  <= 1'b0;
      ers_q   <= 1'b0;
      serr_q  <= 1'b0;
      perr_q  <= 1'b0;
      unp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      pw_ok_q <= pw_ok_d;
      if (ev_ent)      pm_q <= 1'b1;
      else if (ev_pgm) pm_q <= 1'b0;
      if (ev_clr) begin
        prog_q <= 1'b0;
        ers_q  <= 1'b0;
        serr_q <= 1'b0;
        perr_q <= 1'b0;
      end else begin
        if (ev_pgm)   prog_q <= 1'b1;
        if (ev_ers)   ers_q  <= 1'b1;
        if (ev_err)   serr_q <= 1'b1;
        if (ev_badpw) perr_q <= 1'b1;
      end
      if (ev_unp) unp_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_valid_o <= 1'b0;
      op_kind_o  <= OP_SECT_ERASE;
      op_addr_o  <= '0;
    end else begin
      op_valid_o <= op_go;
      if (op_go) begin
        op_addr_o <= wr_addr_i;
        if (ev_ers) op_kind_o <= ev_cfg ? OP_CFG_ERASE : OP_SECT_ERASE;
        else        op_kind_o <= ev_cfg ? OP_CFG_PROG  : OP_PAGE_PROG;
      end
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[SB_BUSY] = busy;
    status_o[SB_PROG] = prog_q;
    status_o[SB_ERS]  = ers_q;
    status_o[SB_PAGE] = pm_q;
    status_o[SB_SERR] = serr_q;
    status_o[SB_PERR] = perr_q;
    status_o[SB_UNP]  = unp_q;
  end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker import fcs_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int PAIRS  = 32,
  parameter int PCNT_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [STATUS_W-1:0] status_o,
  input logic                op_valid_o,
  input logic [PCNT_W-1:0]   pairs_o
);
  wire clr_wr = wr_en_i && wr_addr_i == ADDR_W'(TGT_OFF[T_CMD]) && wr_data_i == C_CLR;
  wire ent_wr = wr_en_i && wr_addr_i == ADDR_W'(TGT_OFF[T_CMD]) && wr_data_i == C_ENT;

  a_r9_busy_with_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> status_o[SB_BUSY]);
  a_r9_busy_rise_from_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[SB_BUSY]) |-> op_valid_o);
  a_r11_busy_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[SB_BUSY] && wr_en_i) |=> status_o[SB_SERR]);
  a_r12_serr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[SB_SERR]) |-> $past(clr_wr));
  a_r4_page_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[SB_PAGE]) |-> $past(ent_wr));
  a_r5_pairs_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pairs_o <= PCNT_W'(PAIRS));
  a_r2_op_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(wr_en_i));
endmodule

bind flash_cmd_decoder fcs_checker #(.ADDR_W(ADDR_W), .PAIRS(PAIRS), .PCNT_W(PCNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .status_o(status_o), .op_valid_o(op_valid_o), .pairs_o(pairs_o));

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int BUSY = 20;
  localparam logic [31:0] K1 = 32'h1234_5678;
  localparam logic [31:0] K2 = 32'h9ABC_DEF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] status;
  logic op_valid;
  logic [1:0] op_kind;
  logic [15:0] op_addr;
  logic [5:0] pairs;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(16), .BUSY_CYCLES(BUSY), .PAGE_BYTES(256),
                      .KEY1(K1), .KEY2(K2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .status_o(status), .op_valid_o(op_valid), .op_kind_o(op_kind), .op_addr_o(op_addr),
    .pairs_o(pairs));

  // behavioural model: pending writes kept as a list, matched against command patterns
  logic [31:0] qa[$];
  logic [31:0] qd[$];
  int busy_left, m_pairs, m_kind;
  bit m_pm, m_prog, m_ers, m_serr, m_perr, m_unp, m_lo, m_opv;
  logic [15:0] m_addr;

  function automatic int classify();
    int n = qa.size();
    if (qa[0] != 32'h5554) return 0;
    if (n == 1) begin
      if (qd[0] == 32'hF5) return 10;
      if (qd[0] == 32'h50) return 11;
      if (qd[0] == 32'hAA) return 1;
      return 0;
    end
    if (qd[0] != 32'hAA) return 0;
    if (!(qa[1] == 32'hAAA8 && qd[1] == 32'h55)) return 0;
    if (n == 2) return 1;
    if (qa[2] == 32'h5554 && qd[2] == 32'h80) begin
      if (n == 3) return 1;
      if (!(qa[3] == 32'h5554 && qd[3] == 32'hAA)) return 0;
      if (n == 4) return 1;
      if (!(qa[4] == 32'hAAA8 && qd[4] == 32'h55)) return 0;
      if (n == 5) return 1;
      if (qd[5] == 32'h30) return 20;
      if (qd[5] == 32'hC0) return 21;
      return 0;
    end
    if (qa[2] == 32'h5554 && (qd[2] == 32'hA0 || qd[2] == 32'hC0)) begin
      if (n == 3) return 1;
      if (qd[3] == 32'hAA) return (qd[2] == 32'hA0) ? 30 : 31;
      return 0;
    end
    if (qa[2] == 32'h553C && qd[2] <= 32'd2) begin
      if (n == 3) return 1;
      if (qa[3] != 32'hAAA8) return 0;
      if (n == 4) return 1;
      if (qa[4] != 32'hAAA8) return 0;
      if (n == 5) return 1;
      if (qa[5] == 32'h5558 && qd[5] == 32'h05) return 40;
      return 0;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa.delete(); qd.delete();
      busy_left = 0; m_pairs = 0; m_kind = 0; m_addr = '0;
      {m_pm, m_prog, m_ers, m_serr, m_perr, m_unp, m_lo, m_opv} = '0;
    end else begin
      bit was_busy;
      int c;
      was_busy = busy_left > 0;
      if (was_busy) busy_left--;
      m_opv = 0;
      if (wr_en) begin
        if (was_busy) m_serr = 1;
        else if (qa.size() == 0 && wr_addr == 16'h55F0) begin
          if (m_pm && !m_lo && m_pairs < 32) m_lo = 1; else m_serr = 1;
        end else if (qa.size() == 0 && wr_addr == 16'h55F4) begin
          if (m_pm && m_lo) begin m_lo = 0; m_pairs++; end else m_serr = 1;
        end else begin
          qa.push_back(32'(wr_addr)); qd.push_back(wr_data);
          c = classify();
          case (c)
            1: ;
            10: begin m_prog = 0; m_ers = 0; m_serr = 0; m_perr = 0; end
            11: begin m_pm = 1; m_pairs = 0; m_lo = 0; end
            20, 21: begin
              m_ers = 1; busy_left = BUSY; m_opv = 1; m_kind = c - 20; m_addr = wr_addr;
            end
            30, 31: begin
              if (m_pm) begin
                m_prog = 1; busy_left = BUSY; m_opv = 1; m_kind = c - 28; m_addr = wr_addr;
                m_pm = 0; m_pairs = 0; m_lo = 0;
              end else m_serr = 1;
            end
            40: if (qd[3] == K1 && qd[4] == K2) m_unp = 1; else m_perr = 1;
            default: m_serr = 1;
          endcase
          if (c != 1) begin qa.delete(); qd.delete(); end
        end
      end
    end
  end

  function automatic logic [15:0] m_status();
    logic [15:0] s = '0;
    s[0] = busy_left > 0; s[4] = m_prog; s[5] = m_ers; s[6] = m_pm;
    s[10] = m_serr; s[11] = m_perr; s[12] = m_unp;
    return s;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "status", int'(status), int'(m_status()));
    chk(cur_req, "op_valid", int'(op_valid), int'(m_opv));
    chk(cur_req, "pairs", int'(pairs), m_pairs);
    if (m_opv) begin
      chk(cur_req, "op_kind", int'(op_kind), m_kind);
      chk(cur_req, "op_addr", int'(op_addr), int'(m_addr));
    end
  end

  task automatic wr(logic [15:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic erase(logic [15:0] base, logic [31:0] fin);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h5554, 32'h80);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(base, fin);
  endtask

  task automatic prog(logic [15:0] base, logic [31:0] sel);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h5554, sel); wr(base, 32'hAA);
  endtask

  task automatic unprot(logic [31:0] lvl, logic [31:0] a, logic [31:0] b);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h553C, lvl);
    wr(16'hAAA8, a); wr(16'hAAA8, b); wr(16'h5558, 32'h05);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R1";
    chk("R1", "status after reset", int'(status), 0);
    chk("R1", "pairs after reset", int'(pairs), 0);

    cur_req = "R2";
    erase(16'h4000, 32'h30);
    chk("R2", "erase+busy", int'(status & 16'h21), 16'h21);
    chk("R2", "op_addr", int'(op_addr), 16'h4000);
    cur_req = "R9";
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
    chk("R9", "busy length", n, BUSY);

    cur_req = "R11";
    erase(16'h8000, 32'hC0);
    chk("R3", "config erase kind", int'(op_kind), 1);
    wr(16'h5554, 32'hF5);
    chk("R11", "write while busy errs", int'(status[10]), 1);
    chk("R11", "clear refused while busy", int'(status[5]), 1);
    idle(BUSY);

    cur_req = "R7";
    wr(16'h5554, 32'hF5);
    chk("R7", "cleared", int'(status), 0);

    cur_req = "R3";
    erase(16'h4000, 32'h31);
    chk("R3", "bad final value errs", int'(status[10]), 1);
    chk("R3", "no op started", int'(status[0]), 0);
    wr(16'h5554, 32'hF5);

    cur_req = "R10";
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h56);
    chk("R10", "wrong data errs", int'(status[10]), 1);
    erase(16'h2000, 32'h30);
    chk("R10", "fresh series accepted", int'(status[5]), 1);
    // write on the last busy cycle: busy falls and error rises on one edge
    idle(BUSY - 1);
    chk("R9", "still busy on last cycle", int'(status[0]), 1);
    wr(16'h1234, 32'h0);
    chk("R11", "busy end", int'(status[0]), 0);
    chk("R11", "error on same edge", int'(status[10]), 1);
    cur_req = "R12";
    idle(30);
    chk("R12", "error sticky", int'(status[10]), 1);
    wr(16'h5554, 32'hF5);
    chk("R12", "error cleared", int'(status[10]), 0);

    cur_req = "R5";
    wr(16'h55F0, 32'h1);
    chk("R5", "low outside page mode", int'(status[10]), 1);
    wr(16'h5554, 32'hF5);
    cur_req = "R4";
    wr(16'h5554, 32'h50);
    chk("R4", "page mode", int'(status[6]), 1);
    cur_req = "R5";
    wr(16'h55F4, 32'h2);
    chk("R5", "high without low", int'(status[10]), 1);
    wr(16'h5554, 32'hF5);
    for (int i = 0; i < 32; i++) begin
      wr(16'h55F0, 32'(i)); wr(16'h55F4, 32'(~i));
    end
    chk("R5", "32 pairs", int'(pairs), 32);
    chk("R5", "no error while loading", int'(status[10]), 0);
    wr(16'h55F0, 32'h0);
    chk("R5", "33rd pair refused", int'(status[10]), 1);
    wr(16'h5554, 32'hF5);
    chk("R7", "page mode kept by clear", int'(status[6]), 1);

    cur_req = "R6";
    prog(16'h0100, 32'hA0);
    chk("R6", "program kind", int'(op_kind), 2);
    chk("R6", "page mode left", int'(status[6]), 0);
    chk("R6", "pairs reset", int'(pairs), 0);
    idle(BUSY);
    wr(16'h5554, 32'h50);
    prog(16'h0200, 32'hC0);
    chk("R6", "config program kind", int'(op_kind), 3);
    idle(BUSY);
    wr(16'h5554, 32'hF5);
    prog(16'h0300, 32'hA0);
    chk("R6", "program without page mode errs", int'(status[10]), 1);
    chk("R6", "no program flag", int'(status[4]), 0);
    wr(16'h5554, 32'hF5);

    cur_req = "R8";
    unprot(32'd3, K1, K2);
    chk("R8", "level 3 errs", int'(status[10]), 1);
    wr(16'h5554, 32'hF5);
    unprot(32'd1, K1, 32'h0);
    chk("R8", "bad key prot error", int'(status[11]), 1);
    chk("R8", "bad key no unprotect", int'(status[12]), 0);
    unprot(32'd0, K1, K2);
    chk("R8", "unprotected", int'(status[12]), 1);
    wr(16'h5554, 32'hF5);
    chk("R7", "unprotect kept, prot error cleared", int'(status), 16'h1000);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule